// File: doc/BRIEF.md
# Eight-Channel Binary-Weighted LED Dimmer

This block dims eight LED outputs using bit-angle modulation. Each output has an 8-bit brightness code. One modulation period is split into eight states, and each state stands for one bit of the code. While the block is in state k, every output shows bit k of its own code. Because state k lasts twice as long as state k-1, the average on-time of an output is proportional to its code.

Timing comes from outside the block. A one-clock `advance` pulse moves the sequencer to its next state. The pulse source must space the pulses so that state k lasts 2^k base slots, which gives a period of 255 slots. As a result, code 0 is fully off, code 255 is fully on, and each code step is 1/255 of the period.

Brightness is written through a plain address/data/enable port. The storage is transposed: word k holds the level of all eight outputs during state k, so output j's code is bit j of words 0 to 7. The output levels are loaded only when a state begins. A write in the middle of a state therefore never glitches the LEDs. A write in the middle of a period can produce one period that mixes the old and new codes.

Top module: `bam_dimmer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the sequencer goes to state 0, all eight brightness words are cleared, and `led` is 0.
- R2: An `advance` pulse moves the state from k to k+1 for k in 0..6, and from state 7 to state 0. Without a pulse the state holds.
- R3: At the edge where `advance` is high, `led` loads the word for the state being entered, taken as it stood before that edge. Bit j of the word drives `led[j]`.
- R4: `led` changes only at an edge with `advance` high. A register write alone never changes `led`, even when it targets the current state's word.
- R5: With `wr_en` high, `wr_addr` values 0..7 update word `wr_addr` with `wr_data` at that edge. Addresses 8..15 change no word.
- R6: Loading word k with the value 1<<k for every k makes `led` one-hot, with only output k high during state k.
- R7: When state k is held for 2^k cycles, output j is high for exactly code_j cycles out of the 255-cycle period. Here code_j is the sum over k of bit j of word k times 2^k. Code 0 gives no high cycles and code 255 gives 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| advance | input | 1 | One-clock pulse that steps to the next state |
| wr_en | input | 1 | Write enable for the brightness words |
| wr_addr | input | 4 | Word index; 0..7 are valid |
| wr_data | input | 8 | Word contents, one bit per output |
| led | output | 8 | Modulated LED levels |

## Verification
On every cycle, the assertions check the state stepping and wrap-around, the hold of the state without a pulse, and that `led` moves only on a pulse. On each pulse they check that `led` equals the word of the state being entered. They also check that legal writes land in the right word, that out-of-range writes leave the bank untouched, and the cleared state after reset. The duty cycle can only be seen over a whole period, so the bench's scenarios cover it. The bench drives states of 1 to 128 cycles and counts high cycles per output for codes such as 0, 1, 128 and 255. The scenarios also cover the one-hot diagonal pattern and a mid-period rewrite of the live word.

// File: rtl/bam_pkg.sv
// Shared constants and helpers for the binary-weighted dimmer.
// Assumes states are numbered from the LSB (state 0) up to the MSB.
package bam_pkg;

    // Number of base slots in one period for a code of nbits bits.
    function automatic int unsigned period_slots(input int unsigned nbits);
        return (32'd1 << nbits) - 32'd1;
    endfunction

endpackage

// File: rtl/bam_sequencer.sv
// State counter: steps 0..NUM_BITS-1 on each advance pulse and wraps to 0.
// Assumes advance is a one-clock pulse; the pulse source sets slot timing.
module bam_sequencer #(
    parameter int NUM_BITS = 8,
    localparam int STATE_W = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    output logic [STATE_W-1:0] state,
    output logic [STATE_W-1:0] state_nxt
);
    localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM_BITS - 1);

    // Successor state with wrap from the MSB state back to the LSB state.
    always_comb begin
        state_nxt = (state == LAST) ? '0 : state + 1'b1;
    end

    // Hold the current state; move on only when a pulse arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= '0;
        else if (advance) state <= state_nxt;
    end
endmodule

// File: rtl/bam_regbank.sv
// Transposed brightness storage: word k holds every output's level in state k.
// Assumes wr_addr values at or above NUM_BITS are to be ignored.
module bam_regbank #(
    parameter int NUM_OUT  = 8,
    parameter int NUM_BITS = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [NUM_OUT-1:0]           wr_data,
    output logic [NUM_BITS*NUM_OUT-1:0]  bank_flat
);
    genvar k;
    generate
        for (k = 0; k < NUM_BITS; k++) begin : g_word
            logic [NUM_OUT-1:0] word_q;
            logic               hit;

            // Decode a write aimed at this word.
            always_comb begin
                hit = wr_en && (wr_addr == ADDR_W'(k));
            end

            // Store the word; cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)   word_q <= '0;
                else if (hit) word_q <= wr_data;
            end

            assign bank_flat[k*NUM_OUT +: NUM_OUT] = word_q;
        end
    endgenerate
endmodule

// File: rtl/bam_outstage.sv
// Output register: on each advance, latches the word of the state being entered.
// Assumes state_nxt is the successor state and is valid in the advance cycle.
module bam_outstage #(
    parameter int NUM_OUT  = 8,
    parameter int NUM_BITS = 8,
    localparam int STATE_W = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         advance,
    input  logic [STATE_W-1:0]           state_nxt,
    input  logic [NUM_BITS*NUM_OUT-1:0]  bank_flat,
    output logic [NUM_OUT-1:0]           led
);
    logic [NUM_OUT-1:0] word_sel;

    // Pick the word that belongs to the upcoming state.
    always_comb begin
        word_sel = bank_flat[state_nxt*NUM_OUT +: NUM_OUT];
    end

    // Update the LED levels only at a state boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       led <= '0;
        else if (advance) led <= word_sel;
    end
endmodule

// File: rtl/bam_dimmer.sv
// Top level: eight-output binary-weighted dimmer with transposed storage.
// Assumes an external source spaces the advance pulses 2^k slots apart in state k.
module bam_dimmer #(
    parameter int NUM_OUT  = 8,
    parameter int NUM_BITS = 8,
    parameter int ADDR_W   = 4,
    localparam int STATE_W = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_OUT-1:0] wr_data,
    output logic [NUM_OUT-1:0] led
);
    logic [STATE_W-1:0]          state_q;
    logic [STATE_W-1:0]          next_state;
    logic [NUM_BITS*NUM_OUT-1:0] bank_flat;

    bam_sequencer #(.NUM_BITS(NUM_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .state     (state_q),
        .state_nxt (next_state)
    );

    bam_regbank #(.NUM_OUT(NUM_OUT), .NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .bank_flat (bank_flat)
    );

    bam_outstage #(.NUM_OUT(NUM_OUT), .NUM_BITS(NUM_BITS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .state_nxt (next_state),
        .bank_flat (bank_flat),
        .led       (led)
    );
endmodule

// File: rtl/bam_dimmer_chk.sv
// Assertion checker for bam_dimmer, attached by bind.
// Assumes it sees the sequencer state and the flattened register bank.
module bam_dimmer_chk #(
    parameter int NUM_OUT  = 8,
    parameter int NUM_BITS = 8,
    parameter int ADDR_W   = 4,
    parameter int STATE_W  = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         advance,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [NUM_OUT-1:0]           wr_data,
    input logic [NUM_OUT-1:0]           led,
    input logic [STATE_W-1:0]           state,
    input logic [NUM_BITS*NUM_OUT-1:0]  bank_flat
);
    localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM_BITS - 1);

    function automatic logic [NUM_OUT-1:0] word_at(
        input logic [NUM_BITS*NUM_OUT-1:0] f, input logic [STATE_W-1:0] i);
        return f[i*NUM_OUT +: NUM_OUT];
    endfunction

    logic rst_seen = 1'b0;

    // Remember that the previous edge saw reset asserted.
    always @(posedge clk) begin
        // R1
        if (rst_seen) begin
            reset_clear_chk: assert (state == '0 && led == '0 && bank_flat == '0)
                else $error("state/led/bank not cleared after reset");
        end
        rst_seen <= !rst_n;
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && state == LAST) |=> (state == '0));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && state != LAST) |=> (state == $past(state) + 1'b1));

    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state));

    // R3
    led_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (led == word_at($past(bank_flat), state)));

    // R4
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(led));

    // R5
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < ADDR_W'(NUM_BITS))
        |=> (word_at(bank_flat, $past(wr_addr[STATE_W-1:0])) == $past(wr_data)));

    // R5
    write_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr < ADDR_W'(NUM_BITS)) |=> $stable(bank_flat));
endmodule

bind bam_dimmer bam_dimmer_chk #(
    .NUM_OUT  (NUM_OUT),
    .NUM_BITS (NUM_BITS),
    .ADDR_W   (ADDR_W),
    .STATE_W  (STATE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .led       (led),
    .state     (state_q),
    .bank_flat (bank_flat)
);

// File: tb/bam_dimmer_test.sv
`timescale 1ns/1ps
module bam_dimmer_test;
    import bam_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       advance = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] led;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model_regs [8];
    int         model_state = 0;
    logic [7:0] model_led = '0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    bam_dimmer uut (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .led(led)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare queued expectations against led after each driver step.
    always begin
        @(negedge clk);
        #1;
        while (exp_q.size() > 0) begin
            check(tag_q.pop_front(), int'(led), int'(exp_q.pop_front()));
        end
    end

    task automatic expect_led(input string tag);
        exp_q.push_back(model_led);
        tag_q.push_back(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        advance = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) model_regs[k] = '0;
        model_state = 0;
        model_led = '0;
        expect_led("R1");
    endtask

    task automatic wr(input int addr, input logic [7:0] data, input string tag);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 4'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (addr < 8) model_regs[addr] = data;
        expect_led(tag);
    endtask

    task automatic adv(input string tag);
        @(negedge clk);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        model_state = (model_state + 1) % 8;
        model_led = model_regs[model_state];
        expect_led(tag);
    endtask

    // Runs one full period with state k held 2^k cycles; counts high cycles.
    task automatic run_period(input bit judge);
        int cnt [8];
        for (int j = 0; j < 8; j++) cnt[j] = 0;
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < (1 << k); c++) begin
                @(negedge clk);
                for (int j = 0; j < 8; j++) cnt[j] += int'(led[j]);
                advance = (c == (1 << k) - 1);
            end
        end
        @(negedge clk);
        advance = 1'b0;
        model_state = 0;
        model_led = model_regs[0];
        if (judge) begin
            for (int j = 0; j < 8; j++) begin
                int code = 0;
                for (int k = 0; k < 8; k++) code += int'(model_regs[k][j]) << k;
                check("R7 duty", cnt[j], code);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [8];
        do_reset();

        // R6 / R2: diagonal pattern walks a single high output through the states.
        for (int k = 0; k < 8; k++) wr(k, 8'(1 << k), "R4 write-no-glitch");
        for (int k = 0; k < 8; k++) adv("R6 R2 diagonal");

        // R4: rewrite the live state's word; led must stay until the next entry.
        wr(0, 8'hAA, "R4 live-word write");
        wr(0, 8'h3C, "R4 live-word write");
        for (int k = 0; k < 8; k++) adv("R3 R2 new word after rewrite");

        // R5: out-of-range addresses leave every word untouched.
        for (int a = 8; a < 16; a++) wr(a, 8'h5A, "R5 ignored address");
        for (int k = 0; k < 8; k++) adv("R5 bank intact");

        // R3: varied pattern across all words.
        for (int k = 0; k < 8; k++) wr(k, 8'(8'h91 ^ (k * 37)), "R4 write-no-glitch");
        for (int k = 0; k < 8; k++) adv("R3 varied words");

        // R7: per-output codes, stored transposed.
        codes[0] = 8'd0;   codes[1] = 8'd255; codes[2] = 8'd1;  codes[3] = 8'd128;
        codes[4] = 8'd127; codes[5] = 8'd2;   codes[6] = 8'd200; codes[7] = 8'd85;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] w = '0;
            for (int j = 0; j < 8; j++) w[j] = codes[j][k];
            wr(k, w, "R4 write-no-glitch");
        end
        run_period(1'b0);
        run_period(1'b1);
        check("R7 period", int'(period_slots(8)), 255);

        // R1: reset mid-stream clears words and state.
        adv("R2 pre-reset");
        adv("R2 pre-reset");
        adv("R2 pre-reset");
        do_reset();
        for (int k = 0; k < 8; k++) adv("R1 cleared words");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule